// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a small microcontroller core to an 8-bit external data memory. The memory sits behind one port that carries both address and data. The core raises a one-cycle request with a 16-bit address, a write flag, write data and a paged-mode flag. The controller first decides whether the address belongs to internal memory or to the external bus. Internal accesses are handed to the internal memory port with a done pulse one cycle later. External accesses run a fixed sequence:
- an address phase, in which the low address byte is driven on the shared port with the latch strobe (ALE) high;
- a strobe phase, in which active-low RD or WR is held for a programmable number of cycles;
- a done phase, in which the strobe is released and the done pulse is raised.

A small control register holds four fields: the wait-state count, an "all accesses external" bit, the ALE idle level and a stack-placement bit. The stack-placement bit is only passed out to the stack logic. The register sits at address 0x8E of the core's register space.

In paged mode only the low byte comes from the request. The high byte is the value of a software-written page port, which the controller forwards unchanged. In normal mode the request's high address byte is driven on a dedicated output for the whole access. A request that arrives while an external access is in progress is kept in a one-entry slot. It is launched once the sequencer is idle again.

Top module: `xbus_ctrl`

## Requirements
- R1: The control register answers at address 0x8E and resets to 0. Bit 0 is the ALE idle select, bit 1 the all-external bit, bits 3:2 the wait-state count and bit 4 the stack-placement bit (copied to `stk_ext_o`). Bits 7:5 always read 0. A write to any other address leaves the register unchanged.
- R2: In the cycle after an external request is accepted, `ale_o` is 1, `ad_oe_o` is 1 and `ad_o` holds the low address byte. In normal mode `hi_addr_o` holds address bits 15:8 from that cycle until the done cycle.
- R3: With wait-state field value W (0 to 3), the active strobe (`rd_n_o` or `wr_n_o`) is low for exactly W+1 consecutive cycles, starting the cycle after the address phase.
- R4: During a read strobe `ad_oe_o` is 0. `rdata_o` takes the value of `ad_i` from the last strobe cycle. `done_o` is 1 for the single cycle right after the strobe.
- R5: During a write strobe and for one cycle after it, `ad_oe_o` is 1 and `ad_o` holds the write data unchanged.
- R6: When the all-external bit is 0 and the effective address is at or below INT_LAST (default 0x0FFF), the access is internal. In the cycle after acceptance `int_req_o` and `done_o` are 1, and `int_addr_o` and `int_we_o` carry the access. `ale_o` stays at its idle level and `ad_oe_o` stays 0. Addresses above INT_LAST go to the external bus.
- R7: When the all-external bit is 1, every address, including those at or below INT_LAST, runs the external sequence.
- R8: Between accesses `ale_o` equals the inverse of the ALE idle select bit, and after reset it is 1. During the strobe and done cycles `ale_o` is 0.
- R9: In paged mode the effective address is {`page_i`, low request byte}. Routing uses this address, `ad_o` carries the low byte, and `hi_addr_o` follows `page_i` one cycle later. The controller never substitutes a byte of its own.
- R10: `rd_n_o` and `wr_n_o` are never low together, and neither is low while `ale_o` is 1.
- R11: A request that arrives during an external access is kept. If it arrives before the done cycle ends, its address phase comes two cycles after the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Control register read-back |
| stk_ext_o | output | 1 | Stack-placement bit for the stack logic |
| req_valid_i | input | 1 | One-cycle access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write data |
| req_paged_i | input | 1 | Paged (8-bit address) mode |
| page_i | input | 8 | Software page port value |
| rdata_o | output | 8 | Captured external read data |
| done_o | output | 1 | Access completion pulse |
| int_req_o | output | 1 | Internal memory access pulse |
| int_we_o | output | 1 | Internal access write flag |
| int_addr_o | output | 16 | Internal access address |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ad_o | output | 8 | Shared port output value |
| ad_oe_o | output | 1 | Shared port output enable |
| ad_i | input | 8 | Shared port input value |
| hi_addr_o | output | 8 | High address byte output |

## Verification
The access path is tried with four kinds of input:
- addresses just below and just above the internal boundary, under both values of the all-external bit, so internal and external routing is told apart on each side;
- paged requests whose page byte moves the effective address across that boundary, so page-based routing is separated from the request's own high byte;
- reads and writes under all four wait-state settings and both ALE idle levels, which separates strobe width and data capture from the idle behaviour;
- a request injected in the middle of an access, which shows that it is held rather than dropped or started early.

Reads return an address-derived byte from a memory model in the bench, so a wrong capture cycle or a wrong address shows up as a data mismatch.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Sequencer phases for one external access
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_STROBE = 2'd2,
    ST_DONE   = 2'd3
  } xbus_state_e;

  // Control register fields, packed so that bit 0 is the ALE idle select
  typedef struct packed {
    logic       stk_ext;
    logic [1:0] ws;
    logic       ext_all;
    logic       ale_low_idle;
  } xbus_cfg_t;

  localparam int XBUS_CFG_W = $bits(xbus_cfg_t);

endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
  import xbus_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output xbus_cfg_t         cfg_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int PAD_W = DATA_W - XBUS_CFG_W;

  xbus_cfg_t cfg_q;
  logic      hit;
  logic      unused_wdata_hi;

  assign hit             = we_i && (addr_i == REG_ADDR);
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:XBUS_CFG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (hit) begin
      cfg_q <= xbus_cfg_t'(wdata_i[XBUS_CFG_W-1:0]);
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{PAD_W{1'b0}}, cfg_q};

  // R1: a write to the register address lands in the next cycle
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == REG_ADDR) |=> (cfg_q == $past(wdata_i[XBUS_CFG_W-1:0])));

  // R1: a write elsewhere leaves the register unchanged
  a_r1_other_addr_ignored: assert property (@(posedge clk) disable iff (rst)
    (!we_i || addr_i != REG_ADDR) |=> $stable(cfg_q));

endmodule

// File: rtl/xbus_req_hold.sv
module xbus_req_hold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic              in_we_i,
  input  logic              in_paged_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [DATA_W-1:0] in_wdata_i,
  input  logic              idle_i,
  output logic              out_valid_o,
  output logic              out_we_o,
  output logic              out_paged_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_wdata_o
);

  logic              pend_v;
  logic              pend_we;
  logic              pend_paged;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;
  logic              take;
  logic              bypass;

  assign out_valid_o = pend_v || in_valid_i;
  assign out_we_o    = pend_v ? pend_we    : in_we_i;
  assign out_paged_o = pend_v ? pend_paged : in_paged_i;
  assign out_addr_o  = pend_v ? pend_addr  : in_addr_i;
  assign out_wdata_o = pend_v ? pend_wdata : in_wdata_i;

  // take: sequencer consumes the presented request this cycle
  assign take   = idle_i && out_valid_o;
  // bypass: the new input request is the one being consumed directly
  assign bypass = take && !pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_we    <= 1'b0;
      pend_paged <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
    end else begin
      if (take && pend_v) begin
        pend_v <= 1'b0;
      end
      if (in_valid_i && !bypass) begin
        pend_v     <= 1'b1;
        pend_we    <= in_we_i;
        pend_paged <= in_paged_i;
        pend_addr  <= in_addr_i;
        pend_wdata <= in_wdata_i;
      end
    end
  end

  // R11: a kept request is not lost while the sequencer is busy
  a_r11_pending_kept: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !idle_i) |=> pend_v);

endmodule

// File: rtl/xbus_router.sv
module xbus_router #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] INT_LAST = 16'h0FFF
) (
  input  logic                     paged_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [ADDR_W-DATA_W-1:0] page_i,
  input  logic                     ext_all_i,
  output logic [ADDR_W-1:0]        eff_addr_o,
  output logic                     is_ext_o
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0] hi_sel;
  logic            unused_addr_hi;

  assign hi_sel         = paged_i ? page_i : addr_i[ADDR_W-1:DATA_W];
  assign eff_addr_o     = {hi_sel, addr_i[DATA_W-1:0]};
  assign is_ext_o       = ext_all_i || (eff_addr_o > INT_LAST);
  assign unused_addr_hi = 1'b0;

  // R7: the all-external bit always routes outward
  always_comb begin
    if (ext_all_i) begin
      a_r7_all_external: assert (is_ext_o);
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WS_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go_i,
  input  logic                     is_ext_i,
  input  logic                     we_i,
  input  logic                     paged_i,
  input  logic [ADDR_W-1:0]        eff_addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [ADDR_W-DATA_W-1:0] page_i,
  input  logic [WS_W-1:0]          ws_i,
  input  logic                     ale_low_idle_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic                     idle_o,
  output logic                     ale_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] hi_addr_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o,
  output logic                     int_req_o,
  output logic                     int_we_o,
  output logic [ADDR_W-1:0]        int_addr_o
);

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int LEN_W = WS_W + 1;

  xbus_state_e       state;
  logic [WS_W-1:0]   cnt;
  logic [WS_W-1:0]   lat_ws;
  logic              lat_we;
  logic              lat_paged;
  logic [DATA_W-1:0] lat_wdata;

  assign idle_o = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      lat_ws     <= '0;
      lat_we     <= 1'b0;
      lat_paged  <= 1'b0;
      lat_wdata  <= '0;
      ale_o      <= 1'b1;
      rd_n_o     <= 1'b1;
      wr_n_o     <= 1'b1;
      ad_o       <= '0;
      ad_oe_o    <= 1'b0;
      hi_addr_o  <= '0;
      rdata_o    <= '0;
      done_o     <= 1'b0;
      int_req_o  <= 1'b0;
      int_we_o   <= 1'b0;
      int_addr_o <= '0;
    end else begin
      done_o    <= 1'b0;
      int_req_o <= 1'b0;
      if (state != ST_IDLE && lat_paged) begin
        hi_addr_o <= page_i;
      end
      case (state)
        ST_IDLE: begin
          ale_o     <= ~ale_low_idle_i;
          ad_oe_o   <= 1'b0;
          hi_addr_o <= page_i;
          if (go_i) begin
            if (is_ext_i) begin
              state     <= ST_ADDR;
              ale_o     <= 1'b1;
              ad_o      <= eff_addr_i[DATA_W-1:0];
              ad_oe_o   <= 1'b1;
              hi_addr_o <= eff_addr_i[ADDR_W-1:DATA_W];
              lat_ws    <= ws_i;
              lat_we    <= we_i;
              lat_paged <= paged_i;
              lat_wdata <= wdata_i;
            end else begin
              int_req_o  <= 1'b1;
              int_we_o   <= we_i;
              int_addr_o <= eff_addr_i;
              done_o     <= 1'b1;
            end
          end
        end
        ST_ADDR: begin
          state <= ST_STROBE;
          ale_o <= 1'b0;
          cnt   <= '0;
          if (lat_we) begin
            wr_n_o  <= 1'b0;
            ad_o    <= lat_wdata;
            ad_oe_o <= 1'b1;
          end else begin
            rd_n_o  <= 1'b0;
            ad_oe_o <= 1'b0;
          end
        end
        ST_STROBE: begin
          if (cnt == lat_ws) begin
            state  <= ST_DONE;
            rd_n_o <= 1'b1;
            wr_n_o <= 1'b1;
            done_o <= 1'b1;
            if (!lat_we) begin
              rdata_o <= ad_i;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: begin
          state   <= ST_IDLE;
          ad_oe_o <= 1'b0;
          ale_o   <= ~ale_low_idle_i;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobe-length counter used only by the width check below
  logic             strobe_on;
  logic [LEN_W-1:0] strobe_len;

  assign strobe_on = !rd_n_o || !wr_n_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_len <= '0;
    end else if (strobe_on) begin
      strobe_len <= strobe_len + 1'b1;
    end else begin
      strobe_len <= '0;
    end
  end

  // R10: read and write strobes are exclusive
  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_o && !wr_n_o));

  // R10: no strobe while the address latch strobe is high
  a_r10_no_strobe_with_ale: assert property (@(posedge clk) disable iff (rst)
    strobe_on |-> !ale_o);

  // R3: strobe length equals wait states plus one
  a_r3_strobe_width: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_on) |-> (strobe_len == LEN_W'(lat_ws) + LEN_W'(1)));

  // R4: the shared port is released for the whole read strobe
  a_r4_read_released: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> !ad_oe_o);

  // R5: write data stays put while the write strobe is low
  a_r5_wdata_steady: assert property (@(posedge clk) disable iff (rst)
    (!wr_n_o && $past(!wr_n_o)) |-> $stable(ad_o));

  // R5: write data held and driven one cycle past the strobe
  a_r5_wdata_after: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n_o) |-> ($stable(ad_o) && ad_oe_o));

  // R4: completion pulse follows a finished strobe
  a_r4_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_on) |-> done_o);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter int                WS_W     = 2,
  parameter logic [7:0]        REG_ADDR = 8'h8E,
  parameter logic [ADDR_W-1:0] INT_LAST = 16'h0FFF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we_i,
  input  logic [7:0]               cfg_addr_i,
  input  logic [DATA_W-1:0]        cfg_wdata_i,
  output logic [DATA_W-1:0]        cfg_rdata_o,
  output logic                     stk_ext_o,
  input  logic                     req_valid_i,
  input  logic                     req_we_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic                     req_paged_i,
  input  logic [ADDR_W-DATA_W-1:0] page_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o,
  output logic                     int_req_o,
  output logic                     int_we_o,
  output logic [ADDR_W-1:0]        int_addr_o,
  output logic                     ale_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [ADDR_W-DATA_W-1:0] hi_addr_o
);

  xbus_cfg_t         cfg;
  logic              hq_valid;
  logic              hq_we;
  logic              hq_paged;
  logic [ADDR_W-1:0] hq_addr;
  logic [DATA_W-1:0] hq_wdata;
  logic [ADDR_W-1:0] eff_addr;
  logic              is_ext;
  logic              seq_idle;

  assign stk_ext_o = cfg.stk_ext;

  xbus_cfg_reg #(
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  xbus_req_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_hold (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (req_valid_i),
    .in_we_i     (req_we_i),
    .in_paged_i  (req_paged_i),
    .in_addr_i   (req_addr_i),
    .in_wdata_i  (req_wdata_i),
    .idle_i      (seq_idle),
    .out_valid_o (hq_valid),
    .out_we_o    (hq_we),
    .out_paged_o (hq_paged),
    .out_addr_o  (hq_addr),
    .out_wdata_o (hq_wdata)
  );

  xbus_router #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .INT_LAST (INT_LAST)
  ) u_route (
    .paged_i    (hq_paged),
    .addr_i     (hq_addr),
    .page_i     (page_i),
    .ext_all_i  (cfg.ext_all),
    .eff_addr_o (eff_addr),
    .is_ext_o   (is_ext)
  );

  xbus_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WS_W   (WS_W)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .go_i           (hq_valid),
    .is_ext_i       (is_ext),
    .we_i           (hq_we),
    .paged_i        (hq_paged),
    .eff_addr_i     (eff_addr),
    .wdata_i        (hq_wdata),
    .page_i         (page_i),
    .ws_i           (cfg.ws),
    .ale_low_idle_i (cfg.ale_low_idle),
    .ad_i           (ad_i),
    .idle_o         (seq_idle),
    .ale_o          (ale_o),
    .rd_n_o         (rd_n_o),
    .wr_n_o         (wr_n_o),
    .ad_o           (ad_o),
    .ad_oe_o        (ad_oe_o),
    .hi_addr_o      (hi_addr_o),
    .rdata_o        (rdata_o),
    .done_o         (done_o),
    .int_req_o      (int_req_o),
    .int_we_o       (int_we_o),
    .int_addr_o     (int_addr_o)
  );

  // R6: an internal access never disturbs the external bus
  a_r6_internal_quiet: assert property (@(posedge clk) disable iff (rst)
    int_req_o |-> (!ad_oe_o && rd_n_o && wr_n_o));

  // R8: the latch strobe is low while a strobe or completion is active
  a_r8_ale_low_in_access: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_o || !wr_n_o || (done_o && !int_req_o)) |-> !ale_o);

endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        stk_ext;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_paged = 1'b0;
  logic [7:0]  page = '0;
  logic [7:0]  rdata;
  logic        done;
  logic        int_req;
  logic        int_we;
  logic [15:0] int_addr;
  logic        ale;
  logic        rd_n;
  logic        wr_n;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic [7:0]  ad_i;
  logic [7:0]  hi_addr;

  always #4 clk = ~clk;

  xbus_ctrl u_dut (
    .clk (clk), .rst (rst),
    .cfg_we_i (cfg_we), .cfg_addr_i (cfg_addr), .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata), .stk_ext_o (stk_ext),
    .req_valid_i (req_valid), .req_we_i (req_we), .req_addr_i (req_addr),
    .req_wdata_i (req_wdata), .req_paged_i (req_paged), .page_i (page),
    .rdata_o (rdata), .done_o (done), .int_req_o (int_req), .int_we_o (int_we),
    .int_addr_o (int_addr), .ale_o (ale), .rd_n_o (rd_n), .wr_n_o (wr_n),
    .ad_o (ad_o), .ad_oe_o (ad_oe), .ad_i (ad_i), .hi_addr_o (hi_addr)
  );

  // External address latch plus memory model: byte derived from address
  function automatic logic [7:0] mem_byte(input logic [7:0] hi, input logic [7:0] lo);
    return lo ^ {hi[3:0], hi[7:4]} ^ 8'h3C;
  endfunction

  logic [7:0] lat_lo = '0;
  always @(posedge clk) if (ale) lat_lo <= ad_o;
  assign ad_i = mem_byte(hi_addr, lat_lo);

  int n_checks = 0;
  int n_fail   = 0;
  int viol     = 0;
  int cyc      = 0;
  bit ended    = 0;

  logic [1:0] cur_ws = '0;
  logic       cur_ext = 1'b0;
  logic       cur_alelow = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // R10 monitor: count illegal strobe combinations
  always @(negedge clk) begin
    if (!rst) begin
      if ((!rd_n && !wr_n) || ((!rd_n || !wr_n) && ale)) viol++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 8'h8E) begin
      cur_ws = d[3:2]; cur_ext = d[1]; cur_alelow = d[0];
    end
  endtask

  task automatic run_access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                            input bit pg, input logic [7:0] pgv);
    logic [15:0] eff;
    bit          ext;
    logic        idle_ale;
    eff      = pg ? {pgv, a[7:0]} : a;
    ext      = cur_ext || (eff > 16'h0FFF);
    idle_ale = ~cur_alelow;
    @(negedge clk);
    page = pgv; req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_paged = pg;
    @(negedge clk);
    req_valid = 1'b0;
    if (!ext) begin
      chk("R6 int_req pulse", 32'(int_req), 32'd1);
      chk("R6 done for internal", 32'(done), 32'd1);
      chk("R6 int_addr", 32'(int_addr), 32'(eff));
      chk("R6 int_we", 32'(int_we), 32'(we));
      chk("R6 bus not driven", 32'(ad_oe), 32'd0);
      chk("R6 ale stays idle", 32'(ale), 32'(idle_ale));
      return;
    end
    chk("R2 ale high in address phase", 32'(ale), 32'd1);
    chk("R2 low address byte", 32'(ad_o), 32'(eff[7:0]));
    chk("R2 port driven", 32'(ad_oe), 32'd1);
    chk(pg ? "R9 page on high byte" : "R2 high address byte", 32'(hi_addr), 32'(eff[15:8]));
    for (int k = 0; k <= int'(cur_ws); k++) begin
      @(negedge clk);
      chk("R3 strobe low", 32'({rd_n, wr_n}), we ? 32'b10 : 32'b01);
      chk("R8 ale low in strobe", 32'(ale), 32'd0);
      chk("R2 high byte held", 32'(hi_addr), 32'(eff[15:8]));
      if (we) begin
        chk("R5 write data driven", 32'({ad_oe, ad_o}), 32'({1'b1, wd}));
      end else begin
        chk("R4 port released in read", 32'(ad_oe), 32'd0);
      end
    end
    @(negedge clk);
    chk("R3 strobe released after ws+1", 32'({rd_n, wr_n}), 32'b11);
    chk("R4 done pulse", 32'(done), 32'd1);
    chk("R8 ale low in done", 32'(ale), 32'd0);
    if (we) begin
      chk("R5 write data held one more cycle", 32'({ad_oe, ad_o}), 32'({1'b1, wd}));
    end else begin
      chk("R4 read data captured", 32'(rdata), 32'(mem_byte(eff[15:8], eff[7:0])));
    end
    @(negedge clk);
    chk("R4 done single cycle", 32'(done), 32'd0);
    chk("R8 ale idle level", 32'(ale), 32'(idle_ale));
    chk("R4 port released after access", 32'(ad_oe), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20117));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 register reset value", 32'(cfg_rdata), 32'h00);
    chk("R8 ale high after reset", 32'(ale), 32'd1);
    chk("R10 strobes idle after reset", 32'({rd_n, wr_n}), 32'b11);
    chk("R4 no done after reset", 32'(done), 32'd0);

    // R1: unused bits read zero, other addresses ignored, stack bit exported
    cfg_wr(8'h8E, 8'hFF);
    chk("R1 upper bits read zero", 32'(cfg_rdata), 32'h1F);
    chk("R1 stack bit output", 32'(stk_ext), 32'd1);
    cfg_wr(8'h8F, 8'h00);
    chk("R1 other address ignored", 32'(cfg_rdata), 32'h1F);
    cfg_wr(8'h8E, 8'h00);
    chk("R1 register cleared", 32'(cfg_rdata), 32'h00);

    // R6: both sides of the boundary with the all-external bit at 0
    run_access(1'b0, 16'h0FFF, 8'h00, 1'b0, 8'h00);
    run_access(1'b0, 16'h1000, 8'h00, 1'b0, 8'h00);
    run_access(1'b1, 16'h0FFF, 8'h5A, 1'b0, 8'h00);
    run_access(1'b1, 16'h1000, 8'hA5, 1'b0, 8'h00);

    // R7: all external, low address goes out
    cfg_wr(8'h8E, 8'h02);
    run_access(1'b0, 16'h0000, 8'h00, 1'b0, 8'h00);
    run_access(1'b0, 16'h0FFF, 8'h00, 1'b0, 8'h00);

    // R9: paged mode, page byte decides routing
    cfg_wr(8'h8E, 8'h04);
    run_access(1'b0, 16'hEEFF, 8'h00, 1'b1, 8'h0F);
    run_access(1'b0, 16'h0034, 8'h00, 1'b1, 8'h10);
    run_access(1'b1, 16'h0021, 8'hC3, 1'b1, 8'hB7);

    // R3 + R8: maximum wait states, ALE idle low
    cfg_wr(8'h8E, 8'h0D);
    run_access(1'b0, 16'h7F80, 8'h00, 1'b0, 8'h00);
    run_access(1'b1, 16'hFFFF, 8'h3E, 1'b0, 8'h00);

    // R11: a request injected mid-access is launched after return to idle
    cfg_wr(8'h8E, 8'h05);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h2345; req_paged = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 first address phase", 32'(ad_o), 32'h45);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h3456; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 first strobe continues", 32'(rd_n), 32'd0);
    @(negedge clk);
    chk("R11 first done", 32'(done), 32'd1);
    chk("R11 first read data", 32'(rdata), 32'(mem_byte(8'h23, 8'h45)));
    @(negedge clk);
    chk("R11 idle cycle before launch", 32'({ale, ad_oe}), 32'b00);
    @(negedge clk);
    chk("R11 held request address phase", 32'({ale, ad_oe, ad_o}), 32'({2'b11, 8'h56}));
    chk("R11 held request high byte", 32'(hi_addr), 32'h34);
    repeat (2) begin
      @(negedge clk);
      chk("R11 held write strobe", 32'({wr_n, ad_o}), 32'({1'b0, 8'h77}));
    end
    @(negedge clk);
    chk("R11 held write done", 32'(done), 32'd1);
    @(negedge clk);

    // Constrained random mix around the boundary
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      logic [1:0]  sel;
      if (i % 8 == 0) cfg_wr(8'h8E, 8'($urandom % 32));
      sel = 2'($urandom % 4);
      case (sel)
        2'd0: a = 16'h0FFF;
        2'd1: a = 16'h1000;
        2'd2: a = 16'($urandom);
        default: a = 16'($urandom % 16'h1000);
      endcase
      run_access(1'($urandom % 2), a, 8'($urandom), 1'($urandom % 4 == 0), 8'($urandom % 32));
    end

    chk("R10 strobe overlap or strobe with ale", 32'(viol), 32'd0);
    finish_run();
  end

endmodule